// File: doc/BRIEF.md
# Upper-Memory Shadow Attribute Decoder

This block classifies a CPU memory address against the chipset configuration and reports where the access belongs. The window from 0xA0000 to 0xFFFFF is divided into twenty-four 16 KB segments. Each segment has its own shadow-enable bit, and that bit steers reads either to on-board DRAM or to the external bus. Writes to a segment follow a rule that depends on its position. The lowest eight segments write wherever their enable bit points. The sixteen upper segments also carry a write-protect bit, one bit for each adjacent pair of segments, and a set protect bit discards the write whatever the enable bit says.

A second, lower window from 0x40000 to 0x9FFFF can be pushed onto the external bus for both directions with a single control bit. All other addresses take the pass-through code, which is DRAM for both reads and writes. The block is purely combinational. A change to any configuration input therefore applies to the very next access, with no pipeline delay. The block produces attribute codes only; the memory data paths live elsewhere.

Top module: `shadow_attr_decoder`

## Requirements
- R1: `seg_hit` is 1 exactly for addresses 0xA0000..0xFFFFF, and `seg_idx` equals (addr − 0xA0000) >> 14 there, giving segment 0 at 0xA0000 and segment 23 at 0xFC000..0xFFFFF.
- R2: Inside the segment window, `rd_route` is 0 (DRAM) when bit `seg_idx` of `shadow_cfg` is set and 1 (external bus) when it is clear. The enable for segment n sits at bit n, so byte k of `shadow_cfg` holds segments 8k..8k+7.
- R3: For segments 0..7, `wr_route` is 2'b00 (DRAM) when the segment's enable bit is set and 2'b01 (external bus) when it is clear.
- R4: For segments 8..23, when bit (n−8)/2 of `wprot_cfg` is set, `wr_route` is 2'b10 (discard), whatever the enable bit holds.
- R5: For segments 8..23 whose protect bit is clear, `wr_route` is 2'b00 when the enable bit is set and 2'b01 when it is clear.
- R6: For addresses 0x40000..0x9FFFF with `low_ext` = 1, `low_hit` is 1, `rd_route` is 1 and `wr_route` is 2'b01.
- R7: For addresses 0x40000..0x9FFFF with `low_ext` = 0, `low_hit` is 1, `rd_route` is 0 and `wr_route` is 2'b00.
- R8: For any address outside both windows, `seg_hit` = 0, `low_hit` = 0, `seg_idx` = 0, `rd_route` = 0 and `wr_route` = 2'b00, whatever the configuration.
- R9: A change to `shadow_cfg`, `wprot_cfg` or `low_ext` shows on the outputs for the current address without waiting for any clock edge.
- R10: `wprot_cfg` has no effect on segments 0..7 or on the lower window. The value 2'b10 never appears outside segments 8..23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | ADDR_W (24) | CPU byte address being classified |
| shadow_cfg | input | NUM_GRP*GRP_W (24) | Shadow-enable bits, bit n for segment n |
| wprot_cfg | input | PROT_W (8) | Write-protect bits, one for each segment pair from segment 8 upward |
| low_ext | input | 1 | Sends the lower window to the external bus when set |
| rd_route | output | 1 | Read target: 0 DRAM, 1 external bus |
| wr_route | output | 2 | Write target: 00 DRAM, 01 external bus, 10 discard |
| seg_hit | output | 1 | Address lies in the segment window |
| low_hit | output | 1 | Address lies in the lower window |
| seg_idx | output | IDX_W (5) | Segment number while `seg_hit` is set, else 0 |

## Verification
The block holds no state. A fault in the segment table or the index decode therefore appears on the ports as soon as the address or configuration settles. It does not linger or appear later. An enable bit indexed from the wrong position makes one segment report the attribute of a neighbour. To expose that, the bench gives the segment under test the opposite value from every other bit. A protect bit mapped to the wrong pair turns up as a discard on the wrong segment, or as a missing discard on the right one. Segment boundaries are probed at both the first and the last byte, which catches an off-by-one in the window compare on the spot.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

   typedef enum logic {
      RD_DRAM = 1'b0,
      RD_BUS  = 1'b1
   } rd_route_e;

   typedef enum logic [1:0] {
      WR_DRAM = 2'b00,
      WR_BUS  = 2'b01,
      WR_DROP = 2'b10
   } wr_route_e;

endpackage

// File: rtl/shd_addr_decode.sv
module shd_addr_decode #(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned SEG_LOG2  = 14,
   parameter int unsigned NUM_SEG   = 24,
   parameter int unsigned SEG_BASE  = 32'h000A_0000,
   parameter int unsigned LOW_BASE  = 32'h0004_0000,
   parameter int unsigned IDX_W     = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              seg_hit,
   output logic              low_hit,
   output logic [IDX_W-1:0]  seg_idx
);
   localparam logic [31:0] SPAN = 32'(NUM_SEG) << SEG_LOG2;

   logic [31:0] a32;
   logic [31:0] off;

   always_comb begin
      a32     = 32'(addr);
      off     = a32 - SEG_BASE;
      seg_hit = (a32 >= SEG_BASE) && (off < SPAN);
      low_hit = (a32 >= LOW_BASE) && (a32 < SEG_BASE);
      seg_idx = seg_hit ? off[SEG_LOG2 +: IDX_W] : '0;
   end

endmodule

// File: rtl/shd_seg_table.sv
module shd_seg_table
   import shadow_attr_pkg::*;
#(
   parameter int unsigned NUM_SEG   = 24,
   parameter int unsigned CFG_W     = 24,
   parameter int unsigned PROT_FROM = 8,
   parameter int unsigned PAIR_SIZE = 2,
   parameter int unsigned PROT_W    = 8
) (
   input  logic [CFG_W-1:0]  shadow_cfg,
   input  logic [PROT_W-1:0] wprot_cfg,
   output rd_route_e         seg_rd [NUM_SEG],
   output wr_route_e         seg_wr [NUM_SEG]
);

   for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
      logic en;
      assign en        = shadow_cfg[n];
      assign seg_rd[n] = en ? RD_DRAM : RD_BUS;

      if (n < PROT_FROM) begin : g_open
         assign seg_wr[n] = en ? WR_DRAM : WR_BUS;
      end else begin : g_guarded
         localparam int unsigned PBIT = (n - PROT_FROM) / PAIR_SIZE;
         always_comb begin
            if (wprot_cfg[PBIT])
               seg_wr[n] = WR_DROP;
            else
               seg_wr[n] = en ? WR_DRAM : WR_BUS;
         end
      end
   end

endmodule

// File: rtl/shd_attr_select.sv
module shd_attr_select
   import shadow_attr_pkg::*;
#(
   parameter int unsigned NUM_SEG = 24,
   parameter int unsigned IDX_W   = 5
) (
   input  logic             seg_hit,
   input  logic             low_hit,
   input  logic [IDX_W-1:0] seg_idx,
   input  logic             low_ext,
   input  rd_route_e        seg_rd [NUM_SEG],
   input  wr_route_e        seg_wr [NUM_SEG],
   output rd_route_e        rd_sel,
   output wr_route_e        wr_sel
);
   rd_route_e pick_rd;
   wr_route_e pick_wr;

   always_comb begin
      pick_rd = RD_DRAM;
      pick_wr = WR_DRAM;
      for (int i = 0; i < NUM_SEG; i++) begin
         if (seg_idx == IDX_W'(i)) begin
            pick_rd = seg_rd[i];
            pick_wr = seg_wr[i];
         end
      end
   end

   always_comb begin
      if (seg_hit) begin
         rd_sel = pick_rd;
         wr_sel = pick_wr;
      end else if (low_hit && low_ext) begin
         rd_sel = RD_BUS;
         wr_sel = WR_BUS;
      end else begin
         rd_sel = RD_DRAM;
         wr_sel = WR_DRAM;
      end
   end

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
   import shadow_attr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned SEG_LOG2  = 14,
   parameter int unsigned NUM_SEG   = 24,
   parameter int unsigned GRP_W     = 8,
   parameter int unsigned PROT_FROM = 8,
   parameter int unsigned PAIR_SIZE = 2,
   parameter int unsigned SEG_BASE  = 32'h000A_0000,
   parameter int unsigned LOW_BASE  = 32'h0004_0000,
   localparam int unsigned NUM_GRP  = (NUM_SEG + GRP_W - 1) / GRP_W,
   localparam int unsigned CFG_W    = NUM_GRP * GRP_W,
   localparam int unsigned PROT_W   = (NUM_SEG - PROT_FROM + PAIR_SIZE - 1) / PAIR_SIZE,
   localparam int unsigned IDX_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CFG_W-1:0]  shadow_cfg,
   input  logic [PROT_W-1:0] wprot_cfg,
   input  logic              low_ext,
   output logic              rd_route,
   output logic [1:0]        wr_route,
   output logic              seg_hit,
   output logic              low_hit,
   output logic [IDX_W-1:0]  seg_idx
);

   if (ADDR_W > 32)
      $fatal(1, "ADDR_W must not exceed 32");
   if (PROT_FROM >= NUM_SEG)
      $fatal(1, "PROT_FROM must lie below NUM_SEG");
   if (PAIR_SIZE == 0)
      $fatal(1, "PAIR_SIZE must be nonzero");
   if (LOW_BASE > SEG_BASE)
      $fatal(1, "lower window must start below the segment window");
   if ((64'(SEG_BASE) + (64'(NUM_SEG) << SEG_LOG2)) > (64'd1 << ADDR_W))
      $fatal(1, "segment window exceeds address space");

   rd_route_e seg_rd [NUM_SEG];
   wr_route_e seg_wr [NUM_SEG];
   rd_route_e rd_sel;
   wr_route_e wr_sel;

   shd_addr_decode #(
      .ADDR_W   (ADDR_W),
      .SEG_LOG2 (SEG_LOG2),
      .NUM_SEG  (NUM_SEG),
      .SEG_BASE (SEG_BASE),
      .LOW_BASE (LOW_BASE),
      .IDX_W    (IDX_W)
   ) u_decode (
      .addr    (addr),
      .seg_hit (seg_hit),
      .low_hit (low_hit),
      .seg_idx (seg_idx)
   );

   shd_seg_table #(
      .NUM_SEG   (NUM_SEG),
      .CFG_W     (CFG_W),
      .PROT_FROM (PROT_FROM),
      .PAIR_SIZE (PAIR_SIZE),
      .PROT_W    (PROT_W)
   ) u_table (
      .shadow_cfg (shadow_cfg),
      .wprot_cfg  (wprot_cfg),
      .seg_rd     (seg_rd),
      .seg_wr     (seg_wr)
   );

   shd_attr_select #(
      .NUM_SEG (NUM_SEG),
      .IDX_W   (IDX_W)
   ) u_select (
      .seg_hit (seg_hit),
      .low_hit (low_hit),
      .seg_idx (seg_idx),
      .low_ext (low_ext),
      .seg_rd  (seg_rd),
      .seg_wr  (seg_wr),
      .rd_sel  (rd_sel),
      .wr_sel  (wr_sel)
   );

   assign rd_route = rd_sel;
   assign wr_route = wr_sel;

endmodule

// File: rtl/shadow_attr_decoder_chk.sv
module shadow_attr_decoder_chk #(
   parameter int unsigned PROT_FROM = 8,
   parameter int unsigned PAIR_SIZE = 2,
   parameter int unsigned CFG_W     = 24,
   parameter int unsigned PROT_W    = 8,
   parameter int unsigned IDX_W     = 5
) (
   input logic [CFG_W-1:0]  shadow_cfg,
   input logic [PROT_W-1:0] wprot_cfg,
   input logic              low_ext,
   input logic              rd_route,
   input logic [1:0]        wr_route,
   input logic              seg_hit,
   input logic              low_hit,
   input logic [IDX_W-1:0]  seg_idx
);
   int unsigned idx;
   int unsigned pbit;
   logic        en;
   logic        prot;

   always_comb begin
      idx  = int'(seg_idx);
      en   = (idx < CFG_W) ? shadow_cfg[idx] : 1'b0;
      pbit = (idx >= PROT_FROM) ? (idx - PROT_FROM) / PAIR_SIZE : 0;
      prot = (idx >= PROT_FROM) && (pbit < PROT_W) && wprot_cfg[pbit];

      AST_ZONE_EXCL: assert (!(seg_hit && low_hit));                                   // R1
      AST_SEG_READ:  assert (!seg_hit || (rd_route == !en));                            // R2
      AST_OPEN_WR:   assert (!(seg_hit && idx < PROT_FROM) || (wr_route == {1'b0, !en})); // R3
      AST_PROT_WINS: assert (!(seg_hit && prot) || (wr_route == 2'b10));                // R4
      AST_UNPROT_WR: assert (!(seg_hit && idx >= PROT_FROM && !prot) || (wr_route == {1'b0, !en})); // R5
      AST_LOW_EXT:   assert (!(low_hit && low_ext) || (rd_route && wr_route == 2'b01)); // R6
      AST_LOW_INT:   assert (!(low_hit && !low_ext) || (!rd_route && wr_route == 2'b00)); // R7
      AST_PASS_THRU: assert (seg_hit || low_hit || (!rd_route && wr_route == 2'b00 && seg_idx == '0)); // R8
      AST_DROP_SCOPE: assert ((wr_route != 2'b10) || (seg_hit && idx >= PROT_FROM));   // R10
   end

endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(
   .PROT_FROM (PROT_FROM),
   .PAIR_SIZE (PAIR_SIZE),
   .CFG_W     (CFG_W),
   .PROT_W    (PROT_W),
   .IDX_W     (IDX_W)
) u_chk (
   .shadow_cfg (shadow_cfg),
   .wprot_cfg  (wprot_cfg),
   .low_ext    (low_ext),
   .rd_route   (rd_route),
   .wr_route   (wr_route),
   .seg_hit    (seg_hit),
   .low_hit    (low_hit),
   .seg_idx    (seg_idx)
);

// File: tb/shadow_attr_decoder_test.sv
module shadow_attr_decoder_test;

   logic        clk = 1'b0;
   logic [23:0] addr = '0;
   logic [23:0] shadow_cfg = '0;
   logic [7:0]  wprot_cfg = '0;
   logic        low_ext = 1'b0;
   logic        rd_route;
   logic [1:0]  wr_route;
   logic        seg_hit;
   logic        low_hit;
   logic [4:0]  seg_idx;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   shadow_attr_decoder uut (
      .addr       (addr),
      .shadow_cfg (shadow_cfg),
      .wprot_cfg  (wprot_cfg),
      .low_ext    (low_ext),
      .rd_route   (rd_route),
      .wr_route   (wr_route),
      .seg_hit    (seg_hit),
      .low_hit    (low_hit),
      .seg_idx    (seg_idx)
   );

   // packed view: {seg_hit, low_hit, seg_idx[4:0], rd_route, wr_route[1:0]}
   function automatic logic [9:0] pack(logic sh, logic lh, logic [4:0] ix, logic rd, logic [1:0] wr);
      return {sh, lh, ix, rd, wr};
   endfunction

   task automatic probe(input logic [23:0] a, input string req, input logic [9:0] exp);
      @(posedge clk);
      addr = a;
      @(negedge clk);
      checks++;
      if (pack(seg_hit, low_hit, seg_idx, rd_route, wr_route) !== exp) begin
         errors++;
         $display("FAIL %s addr=%06h got=%03h exp=%03h", req, a,
                  pack(seg_hit, low_hit, seg_idx, rd_route, wr_route), exp);
      end
   endtask

   // all-zero configuration baseline
   task automatic t_baseline();
      shadow_cfg = '0; wprot_cfg = '0; low_ext = 1'b0;
      probe(24'h000000, "R8", pack(0, 0, 5'd0, 0, 2'b00));
      probe(24'h0A0000, "R1", pack(1, 0, 5'd0, 1, 2'b01));
      probe(24'h0FFFFF, "R1", pack(1, 0, 5'd23, 1, 2'b01));
   endtask

   // every segment, every enable/protect combination, first and last byte
   task automatic t_segments();
      for (int n = 0; n < 24; n++) begin
         for (int en = 0; en < 2; en++) begin
            for (int wp = 0; wp < 2; wp++) begin
               logic [23:0] base;
               logic [1:0]  ew;
               string       tag;
               shadow_cfg = en[0] ? 24'h0 : 24'hFFFFFF;
               shadow_cfg[n] = en[0];
               if (n < 8) begin
                  wprot_cfg = wp[0] ? 8'hFF : 8'h00;
               end else begin
                  wprot_cfg = wp[0] ? 8'h00 : 8'hFF;
                  wprot_cfg[(n - 8) / 2] = wp[0];
               end
               base = 24'h0A0000 + 24'(n) * 24'h4000;
               if (n >= 8 && wp == 1) begin
                  ew = 2'b10; tag = "R4";
               end else begin
                  ew = en[0] ? 2'b00 : 2'b01;
                  tag = (n < 8) ? "R3" : "R5";
               end
               // R1 index and R2 read route checked in the same pack
               probe(base, tag, pack(1, 0, 5'(n), !en[0], ew));
               probe(base + 24'h3FFF, tag, pack(1, 0, 5'(n), !en[0], ew));
            end
         end
      end
   endtask

   task automatic t_low_window();
      shadow_cfg = 24'hFFFFFF; wprot_cfg = 8'hFF;
      low_ext = 1'b1;
      probe(24'h040000, "R6", pack(0, 1, 5'd0, 1, 2'b01));
      probe(24'h09FFFF, "R6", pack(0, 1, 5'd0, 1, 2'b01));
      low_ext = 1'b0;
      probe(24'h040000, "R7", pack(0, 1, 5'd0, 0, 2'b00));
      probe(24'h07ABCD, "R7", pack(0, 1, 5'd0, 0, 2'b00));
   endtask

   task automatic t_outside();
      shadow_cfg = 24'h000000; wprot_cfg = 8'hFF; low_ext = 1'b1;
      probe(24'h03FFFF, "R8", pack(0, 0, 5'd0, 0, 2'b00));
      probe(24'h100000, "R8", pack(0, 0, 5'd0, 0, 2'b00));
      probe(24'h1A0000, "R8", pack(0, 0, 5'd0, 0, 2'b00));
      probe(24'hFFFFFF, "R8", pack(0, 0, 5'd0, 0, 2'b00));
   endtask

   // config change with the address held: visible one half-cycle later
   task automatic t_live_update();
      low_ext = 1'b0; wprot_cfg = 8'h00; shadow_cfg = 24'h0;
      probe(24'h0C8000, "R9", pack(1, 0, 5'd10, 1, 2'b01));
      shadow_cfg[10] = 1'b1;
      probe(24'h0C8000, "R9", pack(1, 0, 5'd10, 0, 2'b00));
      wprot_cfg[1] = 1'b1;
      probe(24'h0C8000, "R9", pack(1, 0, 5'd10, 0, 2'b10));
      low_ext = 1'b1;
      probe(24'h050000, "R9", pack(0, 1, 5'd0, 1, 2'b01));
   endtask

   // protect bits must not reach segments 0..7 or the lower window
   task automatic t_prot_ignored();
      wprot_cfg = 8'hFF; low_ext = 1'b0; shadow_cfg = 24'h0000AA;
      for (int n = 0; n < 8; n++) begin
         logic e;
         e = shadow_cfg[n];
         probe(24'h0A0000 + 24'(n) * 24'h4000 + 24'h1234, "R10",
               pack(1, 0, 5'(n), !e, e ? 2'b00 : 2'b01));
      end
      probe(24'h060000, "R10", pack(0, 1, 5'd0, 0, 2'b00));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      t_baseline();
      t_segments();
      t_low_window();
      t_outside();
      t_live_update();
      t_prot_ignored();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule